// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Register

This block supervises software with a watchdog counter. The counter advances only on a slow clock-enable tick that is separate from the system clock. Software chooses one of eight timeout lengths through a 3-bit select. It restarts the count with a kick strobe. If a whole period passes without a kick, the block raises a one-clock reset request for the rest of the chip.

A protected two-step write is needed to switch the watchdog off. The first write arms a short window of a few system clocks, and only a disable write that lands inside that window takes effect. A single stray write therefore cannot turn the watchdog off.

Beside the counter sits a status register that records why the chip was last reset: power-on, external pin, brown-out, watchdog or debug port. The flags are sticky. Software clears a flag by writing zero to it. A power-on reset wipes every flag except the power-on flag, which it sets. Both registers are reached over a small write/read bus with a one-bit address.

Top module: `wdog_rstcause`

## Requirements
- R1: While `por_n` is low and after it is released, the status register reads 0x01 (power-on flag at bit 0 set, all others clear), the control register reads 0x00, and `sys_rst_req` is low.
- R2: With select value s, `sys_rst_req` rises after the 2^(14+s)-th tick counted from zero without a kick, and it stays high for exactly one system clock.
- R3: The watchdog count changes only on system clocks where `wd_tick` is high; clocks without a tick do not bring the timeout closer.
- R4: A `wd_kick` strobe restarts the count from zero, so that a full period of ticks is again needed before a reset request.
- R5: A control write with bit 0 set turns the watchdog on, with no sequence needed.
- R6: A control write with bit 1 and bit 0 both set opens a disable window. A control write with bit 0 clear that arrives within the next 4 system clocks turns the watchdog off and closes the window.
- R7: A control write with bit 0 clear that arrives with no window open, including one on the fifth clock after the arming write or later, leaves the watchdog on.
- R8: While the watchdog is off, the count is held at zero and no reset request is made, however many ticks arrive.
- R9: Reset events set their status flags: external (`ext_rst_evt`) sets bit 1, brown-out (`bor_rst_evt`) sets bit 2, a watchdog timeout sets bit 3, and debug (`dbg_rst_evt`) sets bit 4. Any of the three event inputs also clears the watchdog count.
- R10: A status write clears each flag (bits 4..0) whose written bit is 0 and leaves alone any flag whose written bit is 1. When an event and a clearing write hit the same flag in the same clock, the event wins.
- R11: Status bit 5 always reads 0. Status bits 7 and 6 are plain read/write storage.
- R12: At address 0, the control register reads back as: bit 0 = enable, bit 1 = disable window open, bits 4..2 = timeout select, bits 7..5 = 0. Address 1 reads the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wd_tick | input | 1 | Slow watchdog clock-enable tick, one system clock wide |
| wd_kick | input | 1 | Watchdog restart strobe |
| ext_rst_evt | input | 1 | Pulse: an external-pin reset took place |
| bor_rst_evt | input | 1 | Pulse: a brown-out reset took place |
| dbg_rst_evt | input | 1 | Pulse: a debug-port reset took place |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = control, 1 = status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected register (combinational) |
| sys_rst_req | output | 1 | One-clock chip reset request on timeout |

## Verification
Two situations are the hardest to reach from the ports: the last clock in which a disable write is still accepted, and the first clock in which it is refused. To reach them, the stimulus arms the window and then idles for exactly three clocks or exactly four clocks before it writes zero to the enable bit. The enable bit is read back after each attempt. Timeouts take tens of thousands of ticks, so they are measured by driving the tick for an exact count and checking the request output on the last tick and on the clock after it. The kick, the disable and the event-clear cases run more ticks in total than one period but start over partway through, so only a counter that was really restarted stays silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned WD_BASE_LOG2 = 14;
  localparam int unsigned WD_SEL_W     = 3;
  localparam int unsigned WD_WIN_CLKS  = 4;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // control register field positions
  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_CHG = 1;
  localparam int unsigned CB_SEL = 2;

  // status flag positions
  localparam int unsigned SF_POR = 0;
  localparam int unsigned SF_EXT = 1;
  localparam int unsigned SF_BOR = 2;
  localparam int unsigned SF_WDG = 3;
  localparam int unsigned SF_DBG = 4;
  localparam int unsigned SF_N   = 5;

  // last count value before a timeout, for a given select
  function automatic int unsigned wd_limit(int unsigned base, int unsigned sel);
    return (32'd1 << (base + sel)) - 32'd1;
  endfunction

  // new flag vector after an optional write-zero-to-clear and a set vector
  function automatic logic [SF_N-1:0] flag_next(logic [SF_N-1:0] cur,
                                                logic wr,
                                                logic [SF_N-1:0] wmask,
                                                logic [SF_N-1:0] setv);
    logic [SF_N-1:0] kept;
    kept = wr ? (cur & wmask) : cur;
    return kept | setv;
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned WIN_CLKS = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ctl_wr,
  input  logic [SEL_W+1:0] ctl_wdata,
  output logic             wd_en,
  output logic [SEL_W-1:0] wd_sel,
  output logic             win_open,
  output logic             dis_evt
);
  import wdog_pkg::*;

  localparam int unsigned WIN_W = $clog2(WIN_CLKS + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             wr_en_bit;
  logic             wr_chg_bit;
  logic             arm_evt;

  assign wr_en_bit  = ctl_wdata[CB_EN];
  assign wr_chg_bit = ctl_wdata[CB_CHG];
  assign win_open   = (win_cnt != '0);
  assign arm_evt    = ctl_wr && wr_en_bit && wr_chg_bit;
  assign dis_evt    = ctl_wr && !wr_en_bit && win_open && wd_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_en   <= 1'b0;
      wd_sel  <= '0;
      win_cnt <= '0;
    end else begin
      if (ctl_wr) begin
        wd_sel <= ctl_wdata[CB_SEL +: SEL_W];
      end
      if (arm_evt) begin
        wd_en   <= 1'b1;
        win_cnt <= WIN_W'(WIN_CLKS);
      end else if (ctl_wr && wr_en_bit) begin
        wd_en <= 1'b1;
        if (win_open) win_cnt <= win_cnt - 1'b1;
      end else if (ctl_wr && !wr_en_bit && win_open) begin
        wd_en   <= 1'b0;
        win_cnt <= '0;
      end else if (win_open) begin
        win_cnt <= win_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned BASE  = 14,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             rst_req
);
  import wdog_pkg::*;

  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(wd_limit(BASE, 32'(sel)));
  assign expire = en && tick && !clr && (count >= limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (!en || clr || expire) begin
        count <= '0;
      end else if (tick) begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        st_wr,
  input  logic [wdog_pkg::SF_N-1:0]   wr_flags,
  input  logic [1:0]                  wr_user,
  input  logic [wdog_pkg::SF_N-1:0]   set_vec,
  output logic [7:0]                  status
);
  import wdog_pkg::*;

  logic [SF_N-1:0] flags_q;
  logic [1:0]      user_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags_q <= SF_N'(1) << SF_POR;
      user_q  <= '0;
    end else begin
      flags_q <= flag_next(flags_q, st_wr, wr_flags, set_vec);
      if (st_wr) user_q <= wr_user;
    end
  end

  assign status = {user_q, 1'b0, flags_q};

endmodule

// File: rtl/wdog_rstcause.sv
module wdog_rstcause #(
  parameter int unsigned BASE_LOG2 = wdog_pkg::WD_BASE_LOG2,
  parameter int unsigned SEL_W     = wdog_pkg::WD_SEL_W,
  parameter int unsigned WIN_CLKS  = wdog_pkg::WD_WIN_CLKS
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wd_tick,
  input  logic       wd_kick,
  input  logic       ext_rst_evt,
  input  logic       bor_rst_evt,
  input  logic       dbg_rst_evt,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sys_rst_req
);
  import wdog_pkg::*;

  localparam int unsigned CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int unsigned CTL_W = SEL_W + 2;

  logic             ctl_wr;
  logic             st_wr;
  logic             wd_en;
  logic [SEL_W-1:0] wd_sel;
  logic             win_open;
  logic             dis_evt;
  logic             chip_evt;
  logic             cnt_clr;
  logic [CNT_W-1:0] wd_count;
  logic             expire;
  logic [SF_N-1:0]  set_vec;
  logic [7:0]       status_val;
  logic [7:0]       ctrl_val;

  assign ctl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
  assign st_wr    = bus_wr && (bus_addr == ADDR_STAT);
  assign chip_evt = ext_rst_evt || bor_rst_evt || dbg_rst_evt;
  assign cnt_clr  = wd_kick || chip_evt;

  always_comb begin
    set_vec         = '0;
    set_vec[SF_EXT] = ext_rst_evt;
    set_vec[SF_BOR] = bor_rst_evt;
    set_vec[SF_WDG] = expire;
    set_vec[SF_DBG] = dbg_rst_evt;
  end

  wdog_ctrl #(.SEL_W(SEL_W), .WIN_CLKS(WIN_CLKS)) u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (bus_wdata[CTL_W-1:0]),
    .wd_en     (wd_en),
    .wd_sel    (wd_sel),
    .win_open  (win_open),
    .dis_evt   (dis_evt)
  );

  wdog_counter #(.BASE(BASE_LOG2), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .tick    (wd_tick),
    .en      (wd_en),
    .clr     (cnt_clr),
    .sel     (wd_sel),
    .count   (wd_count),
    .expire  (expire),
    .rst_req (sys_rst_req)
  );

  rst_cause_reg u_cause (
    .clk      (clk),
    .por_n    (por_n),
    .st_wr    (st_wr),
    .wr_flags (bus_wdata[SF_N-1:0]),
    .wr_user  (bus_wdata[7:6]),
    .set_vec  (set_vec),
    .status   (status_val)
  );

  always_comb begin
    ctrl_val                    = '0;
    ctrl_val[CB_EN]             = wd_en;
    ctrl_val[CB_CHG]            = win_open;
    ctrl_val[CB_SEL +: SEL_W]   = wd_sel;
  end

  assign bus_rdata = (bus_addr == ADDR_STAT) ? status_val : ctrl_val;

endmodule

// File: rtl/wdog_rstcause_chk.sv
module wdog_rstcause_chk #(
  parameter int unsigned CNT_W = 21
) (
  input logic             clk,
  input logic             por_n,
  input logic             tick,
  input logic             kick,
  input logic             wd_en,
  input logic             win_open,
  input logic             dis_evt,
  input logic [CNT_W-1:0] wd_count,
  input logic             sys_rst_req,
  input logic [7:0]       status
);

  a_r2_req_one_clk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |=> !sys_rst_req);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!por_n)
    !tick |=> ($stable(wd_count) || wd_count == '0));

  a_r4_kick_restarts: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> (wd_count == '0));

  a_r6_off_only_in_window: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wd_en) |-> $past(win_open));

  a_r6_disable_takes: assert property (@(posedge clk) disable iff (!por_n)
    dis_evt |=> (!wd_en && !win_open));

  a_r8_off_no_count: assert property (@(posedge clk) disable iff (!por_n)
    !wd_en |=> (wd_count == '0 && !sys_rst_req));

  a_r9_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> status[3]);

  a_r11_bit5_zero: assert property (@(posedge clk) disable iff (!por_n)
    !status[5]);

endmodule

bind wdog_rstcause wdog_rstcause_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .tick        (wd_tick),
  .kick        (wd_kick),
  .wd_en       (wd_en),
  .win_open    (win_open),
  .dis_evt     (dis_evt),
  .wd_count    (wd_count),
  .sys_rst_req (sys_rst_req),
  .status      (status_val)
);

// File: tb/wdog_rstcause_bench.sv
`timescale 1ns/1ps
module wdog_rstcause_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wd_tick = 1'b0;
  logic       wd_kick = 1'b0;
  logic       ext_rst_evt = 1'b0;
  logic       bor_rst_evt = 1'b0;
  logic       dbg_rst_evt = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sys_rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  int req_seen = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_rstcause u_wdog_rstcause (
    .clk(clk), .por_n(por_n), .wd_tick(wd_tick), .wd_kick(wd_kick),
    .ext_rst_evt(ext_rst_evt), .bor_rst_evt(bor_rst_evt), .dbg_rst_evt(dbg_rst_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sys_rst_req) req_seen <= req_seen + 1;
  end

  // {ext, bor, dbg, write} nibble, write data, expected status
  localparam logic [19:0] STAT_VEC [10] = '{
    20'h80003, 20'h40007, 20'h20017, 20'h1FFD7, 20'h1D6D6,
    20'h11212, 20'h10000, 20'h13F00, 20'hA0012, 20'h54044
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ticks(int n);
    wd_tick = 1'b1;
    repeat (n) @(negedge clk);
    wd_tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 190000 && !done) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    // R1: values while held in power-on reset
    rd(1'b1, v); check("R1 status in reset", v, 8'h01);
    check("R1 request in reset", sys_rst_req, 1'b0);
    por_n = 1'b1;
    idle(1);
    rd(1'b1, v); check("R1 status after reset", v, 8'h01);
    rd(1'b0, v); check("R1 control after reset", v, 8'h00);

    // R9 R10 R11: table of events and writes on the status register
    for (int i = 0; i < 10; i++) begin
      ext_rst_evt = STAT_VEC[i][19];
      bor_rst_evt = STAT_VEC[i][18];
      dbg_rst_evt = STAT_VEC[i][17];
      bus_wr      = STAT_VEC[i][16];
      bus_addr    = 1'b1;
      bus_wdata   = STAT_VEC[i][15:8];
      @(negedge clk);
      ext_rst_evt = 1'b0; bor_rst_evt = 1'b0; dbg_rst_evt = 1'b0;
      bus_wr = 1'b0; bus_wdata = 8'h00;
      rd(1'b1, v);
      check($sformatf("R9/R10/R11 status row %0d", i), v, 32'(STAT_VEC[i][7:0]));
    end
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R10 all flags cleared", v, 8'h00);

    // R5 R12: enable with select 0
    wr(1'b0, 8'h01);
    rd(1'b0, v); check("R5 enable readback", v, 8'h01);

    // R2 R3: 2^14 ticks with a tick-free pause in the middle
    req_seen = 0;
    ticks(16000);
    idle(1000);
    check("R3 no request during pause", req_seen, 0);
    ticks(383);
    check("R2 no request one tick early", sys_rst_req, 1'b0);
    ticks(1);
    check("R2 request on final tick", sys_rst_req, 1'b1);
    idle(1);
    check("R2 request lasts one clock", sys_rst_req, 1'b0);
    rd(1'b1, v); check("R9 watchdog flag set", v, 8'h08);

    // R4: kick restarts the period
    req_seen = 0;
    ticks(10000);
    wd_kick = 1'b1; idle(1); wd_kick = 1'b0;
    ticks(10000);
    check("R4 no request after kick", req_seen, 0);
    ticks(6384);
    check("R4 request a full period after kick", sys_rst_req, 1'b1);
    idle(1);

    // R9: an external event clears the count
    req_seen = 0;
    ticks(10000);
    ext_rst_evt = 1'b1; idle(1); ext_rst_evt = 1'b0;
    ticks(10000);
    check("R9 event clears count", req_seen, 0);
    rd(1'b1, v); check("R9 external flag", v, 8'h0A);

    // R6 R8: protected disable, then ticks while off
    wr(1'b0, 8'h03);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R6 disable right after arm", v, 8'h00);
    req_seen = 0;
    ticks(20000);
    check("R8 no request while off", req_seen, 0);

    // R7: disable without arming is ignored
    wr(1'b0, 8'h01);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R7 unarmed disable ignored", v, 8'h01);

    // R6 R12: window readback and last accepted clock
    wr(1'b0, 8'h03);
    rd(1'b0, v); check("R12 window bit reads open", v, 8'h03);
    idle(3);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R6 disable on 4th clock", v, 8'h00);

    // R7: first refused clock
    wr(1'b0, 8'h03);
    idle(4);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R7 disable on 5th clock ignored", v, 8'h01);

    // R2: select 1 gives 2^15 ticks
    wr(1'b0, 8'h05);
    rd(1'b0, v); check("R12 select field readback", v, 8'h05);
    req_seen = 0;
    ticks(32767);
    check("R2 sel1 no request early", req_seen, 0);
    ticks(1);
    check("R2 sel1 request on final tick", sys_rst_req, 1'b1);
    idle(1);

    // R1: power-on reset again wipes flags and control
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(1);
    rd(1'b1, v); check("R1 status after second reset", v, 8'h01);
    rd(1'b0, v); check("R1 control after second reset", v, 8'h00);

    done = 1'b1;
    summary();
  end

endmodule